// File: doc/BRIEF.md
# Cancellable Dual-Rail Latch Pipeline

This block is a chain of latch slots. Data words travel forward through it on dual-rail wires with a four-phase handshake. Cancellations travel backward. A consumer downstream may decide that it no longer needs a value. It then raises a cancel request at the tail. The tail acknowledges the request straight away, and an anti-token enters the last slot. The anti-token moves one slot toward the source in each cycle, provided the slot ahead of it is empty. When it meets a data token, both are destroyed. Because of this, the consumer never stalls waiting for late data it has already decided to discard.

Each slot is empty, holds a token, or holds an anti-token. It never holds both. No arbitration element is used: tokens and anti-tokens meet under fixed local rules. An anti-token that gets back to the first slot waits there. It acknowledges the next source word and destroys it, and raises a one-cycle discard flag. The block is a synchronous model, and slots are chained by a parameter.

Top module: `antitoken_pipe`

## Requirements
- R1: After reset every slot is empty, `in_ack`, `kill_ack` and `drop_evt` are low and `out_rail` is all zero (null).
- R2: Bit i of a word uses rail pair [2i+1] (bit is one) and [2i] (bit is zero). A word is complete when every pair has exactly one rail high. Null is all rails low. `out_rail` is always either null or a complete word.
- R3: `in_ack` rises on the clock edge after a complete input word is accepted. A word is accepted only when the first slot holds no token. `in_ack` falls on the edge after the input is seen null. No new word is taken while `in_ack` is high.
- R4: Tokens advance one slot per cycle into non-token slots and leave in injection order. A word accepted into an empty pipeline appears on `out_rail` DEPTH edges after it was first presented.
- R5: A presented word is held unchanged until `out_ack` is seen high. The output then goes null on the next edge and no further word is presented until `out_ack` has been seen low.
- R6: A cancel request is acknowledged on the next edge unless the last slot already holds an anti-token. `kill_ack` falls on the edge after `kill_req` is seen low.
- R7: An anti-token moves back one slot per cycle through empty slots. After `kill_ack` falls, it reaches the first slot DEPTH-2 edges later in an empty pipeline.
- R8: A token and an anti-token in adjacent slots annihilate each other in one edge. Over any run, the number of words delivered equals the number injected minus the number of cancels. Delivered words keep their relative order.
- R9: A token and an anti-token entering the same empty slot on the same edge both vanish, and neither is passed on.
- R10: An anti-token held in the first slot (or one entering it on the same edge) acknowledges the next source word and discards it. `drop_evt` is high for one cycle, together with the rise of `in_ack`, and that word is never delivered.
- R11: A slot never changes directly between token and anti-token. Cancels issued one after another each remove exactly one later source word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_rail | input | 2*WIDTH | Dual-rail source word |
| in_ack | output | 1 | Source acknowledge |
| drop_evt | output | 1 | One-cycle flag: source word destroyed at the head |
| out_rail | output | 2*WIDTH | Dual-rail output word |
| out_ack | input | 1 | Sink acknowledge |
| kill_req | input | 1 | Cancel request from downstream |
| kill_ack | output | 1 | Cancel acknowledge |

## Verification
The most delicate case is when a forward token and a backward anti-token arrive at the same slot on the same edge. A close second is a cancel landing while the head is accepting a source word. The bench issues a cancel and then launches a word after a chosen number of cycles. That delay selects whether the pair meets across a slot boundary, inside one empty slot, or at the head. Each outcome is judged by the discard flag and by whether the word ever reaches the output. A sweep then moves the cancel over every offset of a word stream, with a free sink and with a stalled sink. Each run is judged on the delivered count (injected minus one) and on the delivered order.

// File: rtl/ap_pkg.sv
package ap_pkg;
  typedef enum logic [1:0] {
    SLOT_EMPTY = 2'd0,
    SLOT_TOKEN = 2'd1,
    SLOT_ANTI  = 2'd2
  } slot_e;
endpackage

// File: rtl/ap_slot.sv
module ap_slot
  import ap_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             left_tok,
  input  logic [WIDTH-1:0] left_data,
  input  logic             left_take,
  input  logic             right_anti,
  input  logic             right_take,
  output slot_e            state,
  output logic [WIDTH-1:0] data
);
  slot_e st_q, st_d;
  logic  cap;

  always_comb begin
    st_d = st_q;
    cap  = 1'b0;
    case (st_q)
      SLOT_EMPTY: begin
        if (left_tok && right_anti) st_d = SLOT_EMPTY;
        else if (left_tok) begin
          st_d = SLOT_TOKEN;
          cap  = 1'b1;
        end else if (right_anti) st_d = SLOT_ANTI;
      end
      SLOT_TOKEN: if (right_take) st_d = SLOT_EMPTY;
      SLOT_ANTI:  if (left_take)  st_d = SLOT_EMPTY;
      default:    st_d = SLOT_EMPTY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= SLOT_EMPTY;
      data <= '0;
    end else begin
      st_q <= st_d;
      if (cap) data <= left_data;
    end
  end

  assign state = st_q;

  assert_tok_never_to_anti_R11: assert property (@(posedge clk) disable iff (rst)
    (st_q == SLOT_TOKEN) |=> (st_q != SLOT_ANTI));
  assert_anti_never_to_tok_R11: assert property (@(posedge clk) disable iff (rst)
    (st_q == SLOT_ANTI) |=> (st_q != SLOT_TOKEN));
  assert_same_cycle_annihilate_R9: assert property (@(posedge clk) disable iff (rst)
    (st_q == SLOT_EMPTY && left_tok && right_anti) |=> (st_q == SLOT_EMPTY));
endmodule

// File: rtl/ap_head.sv
module ap_head
  import ap_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2*WIDTH-1:0] in_rail,
  output logic               in_ack,
  output logic               drop_evt,
  input  slot_e              head_state,
  input  logic               head_right_anti,
  output logic               src_offer,
  output logic [WIDTH-1:0]   src_data
);
  logic complete, is_null, accept, drop_now;
  logic ack_q, drop_q;

  always_comb begin
    complete = 1'b1;
    for (int i = 0; i < WIDTH; i++) begin
      complete    = complete & (in_rail[2*i+1] ^ in_rail[2*i]);
      src_data[i] = in_rail[2*i+1];
    end
  end

  assign is_null   = ~|in_rail;
  assign src_offer = complete & ~ack_q;
  assign accept    = src_offer & (head_state != SLOT_TOKEN);
  assign drop_now  = accept & ((head_state == SLOT_ANTI) ||
                               (head_state == SLOT_EMPTY && head_right_anti));

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_q  <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      if (accept) ack_q <= 1'b1;
      else if (ack_q && is_null) ack_q <= 1'b0;
      drop_q <= drop_now;
    end
  end

  assign in_ack   = ack_q;
  assign drop_evt = drop_q;

  assert_ack_needs_word_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(in_ack) |-> $past(complete));
  assert_ack_release_after_null_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(in_ack) |-> $past(is_null));
  assert_drop_with_ack_R10: assert property (@(posedge clk) disable iff (rst)
    drop_evt |-> $rose(in_ack));
endmodule

// File: rtl/ap_tail.sv
module ap_tail
  import ap_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  slot_e              tail_state,
  input  logic [WIDTH-1:0]   tail_data,
  output logic [2*WIDTH-1:0] out_rail,
  input  logic               out_ack,
  input  logic               kill_req,
  output logic               kill_ack,
  output logic               deliver,
  output logic               kill_take
);
  logic rtz_q, kack_q, presenting, kill_offer;
  logic pairs_ok, all_set;

  assign presenting = (tail_state == SLOT_TOKEN) && !rtz_q;
  assign deliver    = presenting & out_ack;
  assign kill_offer = kill_req & ~kack_q;
  assign kill_take  = kill_offer && (tail_state != SLOT_ANTI) && !deliver;

  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      out_rail[2*i+1] = presenting &  tail_data[i];
      out_rail[2*i]   = presenting & ~tail_data[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rtz_q  <= 1'b0;
      kack_q <= 1'b0;
    end else begin
      if (deliver) rtz_q <= 1'b1;
      else if (rtz_q && !out_ack) rtz_q <= 1'b0;
      if (kill_take) kack_q <= 1'b1;
      else if (kack_q && !kill_req) kack_q <= 1'b0;
    end
  end

  assign kill_ack = kack_q;

  always_comb begin
    pairs_ok = 1'b1;
    all_set  = 1'b1;
    for (int i = 0; i < WIDTH; i++) begin
      pairs_ok = pairs_ok & ~(out_rail[2*i+1] & out_rail[2*i]);
      all_set  = all_set & (out_rail[2*i+1] | out_rail[2*i]);
    end
  end

  assert_out_wellformed_R2: assert property (@(posedge clk) disable iff (rst)
    pairs_ok && (all_set || out_rail == '0));
  assert_kill_ack_needs_req_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(kill_ack) |-> $past(kill_req));
  assert_hold_until_ack_R5: assert property (@(posedge clk) disable iff (rst)
    (out_rail != '0 && !out_ack && !kill_req) |=> $stable(out_rail));
endmodule

// File: rtl/antitoken_pipe.sv
module antitoken_pipe
  import ap_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2*WIDTH-1:0] in_rail,
  output logic               in_ack,
  output logic               drop_evt,
  output logic [2*WIDTH-1:0] out_rail,
  input  logic               out_ack,
  input  logic               kill_req,
  output logic               kill_ack
);
  localparam int LAST = DEPTH - 1;

  slot_e            st  [DEPTH];
  logic [WIDTH-1:0] dat [DEPTH];
  logic             src_offer, deliver, kill_take;
  logic [WIDTH-1:0] src_data;
  logic             head_right_anti;

  ap_head #(.WIDTH(WIDTH)) u_head (
    .clk(clk), .rst(rst), .in_rail(in_rail), .in_ack(in_ack), .drop_evt(drop_evt),
    .head_state(st[0]), .head_right_anti(head_right_anti),
    .src_offer(src_offer), .src_data(src_data)
  );

  generate
    if (DEPTH == 1) begin : g_hra_one
      assign head_right_anti = kill_take;
    end else begin : g_hra_many
      assign head_right_anti = (st[1] == SLOT_ANTI);
    end

    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
      logic             l_tok, l_take, r_anti, r_take;
      logic [WIDTH-1:0] l_data;
      if (s == 0) begin : g_left_src
        assign l_tok  = src_offer;
        assign l_take = src_offer;
        assign l_data = src_data;
      end else begin : g_left_slot
        assign l_tok  = (st[s-1] == SLOT_TOKEN);
        assign l_take = (st[s-1] != SLOT_ANTI);
        assign l_data = dat[s-1];
      end
      if (s == LAST) begin : g_right_sink
        assign r_anti = kill_take;
        assign r_take = deliver | kill_take;
      end else begin : g_right_slot
        assign r_anti = (st[s+1] == SLOT_ANTI);
        assign r_take = (st[s+1] != SLOT_TOKEN);
      end
      ap_slot #(.WIDTH(WIDTH)) u_slot (
        .clk(clk), .rst(rst), .left_tok(l_tok), .left_data(l_data), .left_take(l_take),
        .right_anti(r_anti), .right_take(r_take), .state(st[s]), .data(dat[s])
      );
    end
  endgenerate

  ap_tail #(.WIDTH(WIDTH)) u_tail (
    .clk(clk), .rst(rst), .tail_state(st[LAST]), .tail_data(dat[LAST]),
    .out_rail(out_rail), .out_ack(out_ack), .kill_req(kill_req), .kill_ack(kill_ack),
    .deliver(deliver), .kill_take(kill_take)
  );
endmodule

// File: tb/antitoken_pipe_bench.sv
module antitoken_pipe_bench;
  localparam int DEPTH = 4;
  localparam int WIDTH = 4;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2*WIDTH-1:0] in_rail = '0;
  logic [2*WIDTH-1:0] out_rail;
  logic in_ack, drop_evt, kill_ack;
  logic out_ack = 1'b0;
  logic kill_req = 1'b0;
  logic sink_en = 1'b0;

  int checks = 0, fails = 0;
  logic [WIDTH-1:0] sent [64];
  logic [WIDTH-1:0] recv [64];
  int sent_n = 0, recv_n = 0, drops = 0;
  logic last_drop;

  always #(CLK_PERIOD/2) clk = ~clk;

  antitoken_pipe #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_antitoken_pipe (
    .clk(clk), .rst(rst), .in_rail(in_rail), .in_ack(in_ack), .drop_evt(drop_evt),
    .out_rail(out_rail), .out_ack(out_ack), .kill_req(kill_req), .kill_ack(kill_ack)
  );

  function automatic logic [2*WIDTH-1:0] enc(input logic [WIDTH-1:0] w);
    logic [2*WIDTH-1:0] r;
    for (int i = 0; i < WIDTH; i++) begin
      r[2*i+1] = w[i];
      r[2*i]   = ~w[i];
    end
    return r;
  endfunction

  function automatic logic full_word(input logic [2*WIDTH-1:0] r);
    logic ok = 1'b1;
    for (int i = 0; i < WIDTH; i++) ok = ok & (r[2*i+1] ^ r[2*i]);
    return ok;
  endfunction

  function automatic logic [WIDTH-1:0] dec(input logic [2*WIDTH-1:0] r);
    logic [WIDTH-1:0] w;
    for (int i = 0; i < WIDTH; i++) w[i] = r[2*i+1];
    return w;
  endfunction

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // sink: acknowledges every complete word, records it
  initial begin
    forever begin
      @(negedge clk);
      if (sink_en && !rst) begin
        if (!out_ack && full_word(out_rail)) begin
          recv[recv_n] = dec(out_rail);
          recv_n++;
          out_ack = 1'b1;
        end else if (out_ack && out_rail == '0) begin
          out_ack = 1'b0;
        end
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_rail = '0;
    kill_req = 1'b0;
    out_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    sent_n = 0;
    recv_n = 0;
    drops = 0;
  endtask

  task automatic send(input logic [WIDTH-1:0] w);
    while (in_ack) @(negedge clk);
    in_rail = enc(w);
    sent[sent_n] = w;
    sent_n++;
    @(negedge clk);
    while (!in_ack) @(negedge clk);
    last_drop = drop_evt;
    if (drop_evt) drops++;
    in_rail = '0;
  endtask

  task automatic kill();
    kill_req = 1'b1;
    @(negedge clk);
    while (!kill_ack) @(negedge clk);
    kill_req = 1'b0;
    @(negedge clk);
    while (kill_ack) @(negedge clk);
  endtask

  task automatic check_order(input string tag);
    int j = 0;
    logic ok = 1'b1;
    for (int i = 0; i < recv_n; i++) begin
      while (j < sent_n && sent[j] != recv[i]) j++;
      if (j >= sent_n) ok = 1'b0;
      j++;
    end
    chk(ok, tag, recv_n, sent_n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int cnt;
    logic [WIDTH-1:0] w;
    do_reset();
    // R1 reset state
    chk(in_ack == 1'b0, "R1 in_ack", int'(in_ack), 0);
    chk(kill_ack == 1'b0, "R1 kill_ack", int'(kill_ack), 0);
    chk(drop_evt == 1'b0, "R1 drop_evt", int'(drop_evt), 0);
    chk(out_rail == '0, "R1 out_rail null", int'(out_rail), 0);

    // R4 latency, R2 encoding, R5 hold, R3 ack
    sink_en = 1'b0;
    w = 4'hA;
    in_rail = enc(w);
    cnt = 0;
    while (!full_word(out_rail) && cnt < 20) begin
      @(negedge clk);
      cnt++;
    end
    chk(cnt == DEPTH, "R4 latency", cnt, DEPTH);
    chk(in_ack == 1'b1, "R3 in_ack high after accept", int'(in_ack), 1);
    in_rail = '0;
    chk(out_rail == enc(w), "R2 output rails", int'(out_rail), int'(enc(w)));
    repeat (3) @(negedge clk);
    chk(out_rail == enc(w), "R5 held without ack", int'(out_rail), int'(enc(w)));
    chk(in_ack == 1'b0, "R3 in_ack falls after null", int'(in_ack), 0);
    sink_en = 1'b1;
    repeat (4) @(negedge clk);
    chk(recv_n == 1 && recv[0] == w, "R5 delivered once", recv_n, 1);
    chk(out_rail == '0, "R5 null after ack", int'(out_rail), 0);

    // R4 FIFO over all words
    do_reset();
    for (int v = 0; v < 16; v++) send(v[WIDTH-1:0]);
    repeat (30) @(negedge clk);
    chk(recv_n == 16, "R4 count", recv_n, 16);
    for (int v = 0; v < 16; v++)
      chk(recv[v] == v[WIDTH-1:0], "R4 order", int'(recv[v]), v);

    // R6/R7/R10: cancel into empty pipe, word launched after anti reaches head
    do_reset();
    kill();
    chk(kill_ack == 1'b0, "R6 kill_ack released", int'(kill_ack), 0);
    repeat (DEPTH-2) @(negedge clk);
    send(4'h5);
    chk(last_drop == 1'b1, "R7 R10 head discard", int'(last_drop), 1);
    repeat (15) @(negedge clk);
    chk(recv_n == 0, "R10 discarded word absent", recv_n, 0);
    send(4'h9);
    chk(last_drop == 1'b0, "R10 next word kept", int'(last_drop), 0);
    repeat (15) @(negedge clk);
    chk(recv_n == 1 && recv[0] == 4'h9, "R10 next word delivered", recv_n, 1);

    // R9: token and anti enter the same empty slot together
    do_reset();
    kill();
    repeat (DEPTH-3) @(negedge clk);
    send(4'h3);
    chk(last_drop == 1'b1, "R9 same-slot meet", int'(last_drop), 1);
    repeat (15) @(negedge clk);
    chk(recv_n == 0, "R9 nothing passed on", recv_n, 0);

    // R8: meet across a slot boundary
    do_reset();
    kill();
    send(4'h6);
    chk(last_drop == 1'b0, "R8 cross meet no drop", int'(last_drop), 0);
    repeat (15) @(negedge clk);
    chk(recv_n == 0, "R8 cross meet removed", recv_n, 0);

    // R11: two cancels remove two later words
    do_reset();
    kill();
    kill();
    repeat (10) @(negedge clk);
    send(4'h1);
    send(4'h2);
    send(4'h4);
    repeat (20) @(negedge clk);
    chk(drops == 2, "R11 two discards", drops, 2);
    chk(recv_n == 1 && recv[0] == 4'h4, "R11 survivor", recv_n, 1);

    // R8 sweep: cancel at every offset of a stream, free and stalled sink
    for (int v = 0; v < 2; v++) begin
      for (int d = 0; d < 14; d++) begin
        do_reset();
        fork
          begin
            for (int i = 0; i < 6; i++) send(4'd8 + i[WIDTH-1:0]);
          end
          begin
            repeat (d) @(negedge clk);
            kill();
          end
          begin
            if (v == 1) begin
              sink_en = 1'b0;
              repeat (2*DEPTH) @(negedge clk);
              sink_en = 1'b1;
            end
          end
        join
        send(4'hF);
        repeat (40) @(negedge clk);
        chk(recv_n == sent_n - 1, "R8 conservation", recv_n, sent_n - 1);
        check_order("R8 order kept");
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule